// File: doc/BRIEF.md
# Rotating Interrupt Bus Arbiter

This block decides which of several interrupt-accepting agents takes the next delivery on a shared interrupt bus. Each agent carries a small arbitration number. When a request mask is presented with an arbitrate strobe, the requesting agent with the largest number is granted. All numbers then rotate: the winner falls to the bottom and every other agent climbs one step. Over a run of grants the priority therefore moves fairly across the agents.

A resync strobe sets every arbitration number back to that agent's fixed hardware identifier. Hardware reset applies the same load. A second strobe starts a multi-target delivery. The block then grants once per set bit of the request mask on consecutive cycles. This gives the ordered list of targets in the order they should be triggered, and a done flag marks the last entry.

Top module: `rot_bus_arbiter`

## Requirements
- R1: While rstN is low at a clock edge, every agent's arbitration number (4 bits, agent i in arbIds[4i+3:4i]) is loaded from its hardware identifier (agentId[4i+3:4i]), and winnerValid and seqDone are cleared.
- R2: Among the agents whose reqMask bit is set, the one with the largest arbitration number is granted. On a tie the lowest agent index wins.
- R3: A grant is registered. winnerIdx and winnerValid change on the clock edge that samples the strobe. The arbitration numbers update on that same edge. winnerValid is high for exactly one cycle per grant.
- R4: After a grant, the winner's arbitration number is 0.
- R5: After a grant, every other agent's number goes up by one, whether or not it was requesting. An agent that held 15 instead becomes the winner's number before the grant plus one, modulo 16.
- R6: An arbitrate or sequence strobe with an all-zero reqMask grants nothing and leaves all arbitration numbers unchanged.
- R7: resyncStrobe reloads every arbitration number from agentId on the next edge, whatever the mask. It outranks both other strobes, produces no grant in that cycle and cancels any sequence in progress.
- R8: seqStrobe with a nonzero mask produces popcount(reqMask) grants, one on each consecutive edge, starting with the edge that samples the strobe. Every round arbitrates the mask captured at the strobe. Arbitrate and sequence strobes are ignored until the sequence ends.
- R9: seqDone is high together with the final grant of a sequence and low at all other times, including for single grants.
- R10: When seqStrobe and arbStrobe are both high in the same idle cycle, the sequence strobe takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| agentId | input | NUM_AGENTS*ID_W | Fixed hardware identifier of each agent, packed by agent index |
| reqMask | input | NUM_AGENTS | Agents competing for the grant |
| arbStrobe | input | 1 | Request a single arbitration |
| seqStrobe | input | 1 | Request one grant per set mask bit |
| resyncStrobe | input | 1 | Reload all arbitration numbers from agentId |
| winnerIdx | output | IDX_W | Index of the most recent winner |
| winnerValid | output | 1 | A grant was made on the last edge |
| seqDone | output | 1 | The last grant of a sequence was made on the last edge |
| arbIds | output | NUM_AGENTS*ID_W | Current arbitration number of each agent |

## Verification
A corrupted arbitration number can sit unnoticed in the register file, because it only affects a later choice of winner. For that reason the full number vector is compared after every grant and every resync, so a bad rotation is caught on the edge that produced it. A wrong sequence counter shows up as a missing, extra or misplaced done flag within the length of that sequence. Near-exhaustive mask sweeps under identifier patterns with ties and saturated values cover the tie-break and the rule for agents at 15.

// File: rtl/rot_arb_pkg.sv
package rot_arb_pkg;
  // strobes from the sequencing control to the identifier datapath
  typedef struct packed {
    logic reload;  // load every number from its hardware identifier
    logic grant;   // arbitrate the active mask on this edge
    logic last;    // this grant closes a sequence
  } arbCtrl_t;
endpackage

// File: rtl/rot_arb_ctrl.sv
module rot_arb_ctrl
  import rot_arb_pkg::*;
#(
  parameter int NUM_AGENTS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_AGENTS-1:0] reqMask,
  input  logic                  arbStrobe,
  input  logic                  seqStrobe,
  input  logic                  resyncStrobe,
  output arbCtrl_t              ctrl,
  output logic [NUM_AGENTS-1:0] activeMask
);
  localparam int CNT_W = $clog2(NUM_AGENTS + 1);

  logic                  busy, busyNext;
  logic [CNT_W-1:0]      remaining, remainingNext;
  logic [NUM_AGENTS-1:0] heldMask, heldMaskNext;
  logic [CNT_W-1:0]      reqCount;

  always_comb begin
    reqCount = '0;
    for (int i = 0; i < NUM_AGENTS; i++) begin
      reqCount = reqCount + CNT_W'(reqMask[i]);
    end
  end

  always_comb begin
    ctrl          = '0;
    busyNext      = busy;
    remainingNext = remaining;
    heldMaskNext  = heldMask;
    activeMask    = busy ? heldMask : reqMask;
    if (resyncStrobe) begin
      ctrl.reload = 1'b1;
      busyNext    = 1'b0;
    end else if (busy) begin
      ctrl.grant    = 1'b1;
      ctrl.last     = (remaining == CNT_W'(1));
      remainingNext = remaining - CNT_W'(1);
      busyNext      = (remaining != CNT_W'(1));
    end else if (seqStrobe && (reqMask != '0)) begin
      ctrl.grant    = 1'b1;
      ctrl.last     = (reqCount == CNT_W'(1));
      heldMaskNext  = reqMask;
      remainingNext = reqCount - CNT_W'(1);
      busyNext      = (reqCount != CNT_W'(1));
    end else if (arbStrobe && (reqMask != '0)) begin
      ctrl.grant = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      remaining <= '0;
      heldMask  <= '0;
    end else begin
      busy      <= busyNext;
      remaining <= remainingNext;
      heldMask  <= heldMaskNext;
    end
  end
endmodule

// File: rtl/rot_arb_datapath.sv
module rot_arb_datapath
  import rot_arb_pkg::*;
#(
  parameter int NUM_AGENTS = 8,
  parameter int ID_W       = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_AGENTS*ID_W-1:0] agentId,
  input  arbCtrl_t                   ctrl,
  input  logic [NUM_AGENTS-1:0]      activeMask,
  output logic [$clog2(NUM_AGENTS)-1:0] winnerIdx,
  output logic                       winnerValid,
  output logic                       seqDone,
  output logic [NUM_AGENTS*ID_W-1:0] arbIds
);
  localparam int IDX_W = $clog2(NUM_AGENTS);
  localparam logic [ID_W-1:0] ID_MAX = '1;

  logic [ID_W-1:0]  idReg [NUM_AGENTS];
  logic [IDX_W-1:0] winSel;
  logic [ID_W-1:0]  winId;
  logic             found;

  // ascending scan with strict compare: ties go to the lowest index
  always_comb begin
    winSel = '0;
    winId  = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_AGENTS; i++) begin
      if (activeMask[i] && (!found || (idReg[i] > winId))) begin
        found  = 1'b1;
        winSel = IDX_W'(i);
        winId  = idReg[i];
      end
    end
  end

  for (genvar g = 0; g < NUM_AGENTS; g++) begin : gAgent
    always_ff @(posedge clk) begin
      if (!rstN || ctrl.reload) begin
        idReg[g] <= agentId[g*ID_W +: ID_W];
      end else if (ctrl.grant) begin
        if (winSel == IDX_W'(g)) begin
          idReg[g] <= '0;
        end else if (idReg[g] == ID_MAX) begin
          idReg[g] <= winId + ID_W'(1);
        end else begin
          idReg[g] <= idReg[g] + ID_W'(1);
        end
      end
    end
    assign arbIds[g*ID_W +: ID_W] = idReg[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winnerIdx   <= '0;
      winnerValid <= 1'b0;
      seqDone     <= 1'b0;
    end else begin
      winnerValid <= ctrl.grant;
      seqDone     <= ctrl.grant && ctrl.last;
      if (ctrl.grant) begin
        winnerIdx <= winSel;
      end
    end
  end
endmodule

// File: rtl/rot_bus_arbiter.sv
module rot_bus_arbiter
  import rot_arb_pkg::*;
#(
  parameter int NUM_AGENTS = 8,
  parameter int ID_W       = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_AGENTS*ID_W-1:0]    agentId,
  input  logic [NUM_AGENTS-1:0]         reqMask,
  input  logic                          arbStrobe,
  input  logic                          seqStrobe,
  input  logic                          resyncStrobe,
  output logic [$clog2(NUM_AGENTS)-1:0] winnerIdx,
  output logic                          winnerValid,
  output logic                          seqDone,
  output logic [NUM_AGENTS*ID_W-1:0]    arbIds
);
  arbCtrl_t              ctrl;
  logic [NUM_AGENTS-1:0] activeMask;

  rot_arb_ctrl #(.NUM_AGENTS(NUM_AGENTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqMask(reqMask), .arbStrobe(arbStrobe),
    .seqStrobe(seqStrobe), .resyncStrobe(resyncStrobe),
    .ctrl(ctrl), .activeMask(activeMask)
  );

  rot_arb_datapath #(.NUM_AGENTS(NUM_AGENTS), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .agentId(agentId), .ctrl(ctrl),
    .activeMask(activeMask), .winnerIdx(winnerIdx),
    .winnerValid(winnerValid), .seqDone(seqDone), .arbIds(arbIds)
  );
endmodule

// File: rtl/rot_bus_arbiter_chk.sv
module rot_bus_arbiter_chk #(
  parameter int NUM_AGENTS = 8,
  parameter int ID_W       = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [NUM_AGENTS*ID_W-1:0]    agentId,
  input logic [NUM_AGENTS-1:0]         reqMask,
  input logic                          arbStrobe,
  input logic                          resyncStrobe,
  input logic [$clog2(NUM_AGENTS)-1:0] winnerIdx,
  input logic                          winnerValid,
  input logic                          seqDone,
  input logic [NUM_AGENTS*ID_W-1:0]    arbIds
);
  logic primed;
  always_ff @(posedge clk) primed <= rstN;

  // R4: the granted agent sits at the bottom right after its grant
  assert_winner_cleared_R4: assert property (@(posedge clk) disable iff (!rstN || !primed)
    winnerValid |-> (arbIds[winnerIdx*ID_W +: ID_W] == '0));

  // R3: a strobe with a nonzero mask always yields a grant on the next edge
  assert_grant_follows_R3: assert property (@(posedge clk) disable iff (!rstN || !primed)
    $past(arbStrobe && (reqMask != '0) && !resyncStrobe) |-> winnerValid);

  // R6: with no grant and no resync the numbers hold
  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rstN || !primed)
    (!winnerValid && !$past(resyncStrobe)) |-> $stable(arbIds));

  // R7: resync loads the identifiers and grants nothing
  assert_resync_load_R7: assert property (@(posedge clk) disable iff (!rstN || !primed)
    $past(resyncStrobe) |-> ((arbIds == $past(agentId)) && !winnerValid));

  // R9: the done flag only accompanies a grant
  assert_done_with_grant_R9: assert property (@(posedge clk) disable iff (!rstN || !primed)
    seqDone |-> winnerValid);
endmodule

bind rot_bus_arbiter rot_bus_arbiter_chk #(.NUM_AGENTS(NUM_AGENTS), .ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .agentId(agentId), .reqMask(reqMask),
  .arbStrobe(arbStrobe), .resyncStrobe(resyncStrobe), .winnerIdx(winnerIdx),
  .winnerValid(winnerValid), .seqDone(seqDone), .arbIds(arbIds)
);

// File: tb/rot_bus_arbiter_bench.sv
module rot_bus_arbiter_bench;
  localparam int N = 8;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N*W-1:0] agentId = '0;
  logic [N-1:0] reqMask = '0;
  logic         arbStrobe = 1'b0;
  logic         seqStrobe = 1'b0;
  logic         resyncStrobe = 1'b0;
  logic [2:0]   winnerIdx;
  logic         winnerValid;
  logic         seqDone;
  logic [N*W-1:0] arbIds;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] mIds [N];

  always #4 clk = ~clk;

  rot_bus_arbiter #(.NUM_AGENTS(N), .ID_W(W)) u_rot_bus_arbiter (
    .clk(clk), .rstN(rstN), .agentId(agentId), .reqMask(reqMask),
    .arbStrobe(arbStrobe), .seqStrobe(seqStrobe), .resyncStrobe(resyncStrobe),
    .winnerIdx(winnerIdx), .winnerValid(winnerValid), .seqDone(seqDone),
    .arbIds(arbIds)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] modelVec();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = mIds[i];
    return v;
  endfunction

  function automatic int pickWinner(logic [N-1:0] m);
    int w = -1;
    for (int i = 0; i < N; i++)
      if (m[i] && (w < 0 || mIds[i] > mIds[w])) w = i;
    return w;
  endfunction

  task automatic applyGrant(int w);
    logic [W-1:0] wOld = mIds[w];
    for (int i = 0; i < N; i++) begin
      if (i == w) mIds[i] = '0;
      else if (mIds[i] == 4'hF) mIds[i] = wOld + 4'd1;
      else mIds[i] = mIds[i] + 4'd1;
    end
  endtask

  task automatic setPattern(int p);
    for (int i = 0; i < N; i++) begin
      case (p)
        0: agentId[i*W +: W] = 4'(i);
        1: agentId[i*W +: W] = 4'(7 - i);
        2: agentId[i*W +: W] = 4'd5;
        default: agentId[i*W +: W] = (i % 2 == 0 || i == 1) ? 4'hF : 4'(2 * i);
      endcase
    end
  endtask

  task automatic doResync(string req);
    @(negedge clk);
    resyncStrobe = 1'b1;
    @(negedge clk);
    resyncStrobe = 1'b0;
    for (int i = 0; i < N; i++) mIds[i] = agentId[i*W +: W];
    chk(arbIds == modelVec() && !winnerValid, req, "resync load", arbIds, modelVec());
  endtask

  task automatic doArb(logic [N-1:0] m);
    int w;
    @(negedge clk);
    reqMask = m; arbStrobe = 1'b1;
    @(negedge clk);
    arbStrobe = 1'b0;
    w = pickWinner(m);
    if (w < 0) begin
      chk(!winnerValid, "R6", "zero mask valid", winnerValid, 0);
      chk(arbIds == modelVec(), "R6", "zero mask ids", arbIds, modelVec());
    end else begin
      // R2 winner choice, R3 registered grant, R9 no done on single grant
      chk(winnerValid && winnerIdx == 3'(w) && !seqDone, "R2",
          "winner", {winnerValid, seqDone, winnerIdx}, {1'b1, 1'b0, 3'(w)});
      applyGrant(w);
      // R4 winner cleared, R5 rotation of the others
      chk(arbIds == modelVec(), "R5", "rotated ids", arbIds, modelVec());
    end
  endtask

  task automatic doSeq(logic [N-1:0] m, bit noise, bit alsoArb);
    int pop = $countones(m);
    int w;
    @(negedge clk);
    reqMask = m; seqStrobe = 1'b1; arbStrobe = alsoArb;
    for (int k = 0; k < pop; k++) begin
      @(negedge clk);
      if (noise && k < pop - 1) begin
        seqStrobe = 1'b1; arbStrobe = 1'b1; reqMask = ~m;
      end else begin
        seqStrobe = 1'b0; arbStrobe = 1'b0; reqMask = '0;
      end
      w = pickWinner(m);
      chk(winnerValid && winnerIdx == 3'(w) && seqDone == (k == pop - 1),
          alsoArb ? "R10" : "R8", "sequence grant",
          {winnerValid, seqDone, winnerIdx}, {1'b1, k == pop - 1, 3'(w)});
      applyGrant(w);
      chk(arbIds == modelVec(), "R8", "sequence ids", arbIds, modelVec());
    end
    @(negedge clk);
    chk(!winnerValid && !seqDone, "R9", "after sequence", {winnerValid, seqDone}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int w;
    setPattern(3);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < N; i++) mIds[i] = agentId[i*W +: W];
    @(negedge clk);
    chk(arbIds == modelVec() && !winnerValid && !seqDone, "R1", "reset state",
        arbIds, modelVec());

    // single arbitration sweeps over every mask under each identifier pattern
    for (int p = 0; p < 4; p++) begin
      setPattern(p);
      doResync("R7");
      for (int m = 0; m < 256; m++) doArb(8'(m));
    end

    // one-cycle pulse on winnerValid
    doArb(8'hFF);
    @(negedge clk);
    chk(!winnerValid, "R3", "valid pulse width", winnerValid, 0);

    // sequences, with ignored strobes while busy and with a combined strobe
    setPattern(3);
    doResync("R7");
    doSeq(8'hFF, 1'b0, 1'b0);
    doSeq(8'hA5, 1'b1, 1'b0);
    doSeq(8'h01, 1'b0, 1'b0);
    doSeq(8'h30, 1'b1, 1'b0);
    doSeq(8'h0C, 1'b0, 1'b1);

    // zero-mask sequence strobe does nothing
    @(negedge clk);
    reqMask = '0; seqStrobe = 1'b1;
    @(negedge clk);
    seqStrobe = 1'b0;
    chk(!winnerValid && arbIds == modelVec(), "R6", "zero mask sequence",
        arbIds, modelVec());

    // resync in the middle of a sequence cancels it
    @(negedge clk);
    reqMask = 8'hFF; seqStrobe = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      seqStrobe = 1'b0; reqMask = '0;
      w = pickWinner(8'hFF);
      chk(winnerValid && winnerIdx == 3'(w), "R8", "pre-resync grant", winnerIdx, w);
      applyGrant(w);
    end
    resyncStrobe = 1'b1;
    @(negedge clk);
    resyncStrobe = 1'b0;
    for (int i = 0; i < N; i++) mIds[i] = agentId[i*W +: W];
    chk(!winnerValid && arbIds == modelVec(), "R7", "resync mid sequence",
        arbIds, modelVec());
    @(negedge clk);
    chk(!winnerValid && !seqDone && arbIds == modelVec(), "R7", "sequence cancelled",
        {winnerValid, seqDone}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule